// File: doc/BRIEF.md
# Sign and Zero Extend Unit

This execution unit widens a 64-bit source value from a chosen bit position. It serves move-with-extend and convert operations. In sign mode, the unit finds the sign bit at a position that wraps at the operand size. It copies that bit into every higher bit inside the operand. The finished value is merged into the previous destination, so bytes above the operand size keep their old contents. In zero mode, the unit keeps the bits at and below the given index and clears every bit above it.

A sign-mode request can also update four flag bits. The sign bit sets or clears each flag that a per-request enable mask selects. Each request takes one cycle. The result, the flags and a valid strobe are registered.

Top module: `sx_zx_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise. Reset clears `out_valid`, `result` and `flags_out` to zero.
- R2: The operand size is encoded as `size_code` 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. In sign mode (`op_sign`=1), the sign position is `bit_idx` masked with (size in bits minus 1), so for example index 12 at byte size selects bit 4.
- R3: In sign mode, bits above the sign position and inside the operand size equal the sign bit. Bits at and below the position pass through from `src`.
- R4: In sign mode, bytes of `result` above the operand size equal the matching bytes of `old_dest`.
- R5: If `flag_upd` is 1 in sign mode, every flag selected by `flag_mask` is set when the sign bit is 1 and cleared when it is 0. Flag bit order: bit0 carry, bit1 extended carry, bit2 zero, bit3 extended zero.
- R6: Flags not selected by `flag_mask` equal `old_flags`. If `flag_upd` is 0, or the request is a zero-mode request, all four flags equal `old_flags`.
- R7: In zero mode (`op_sign`=0), `result` bits 0 to `bit_idx` equal `src` and all higher bits of the 64 are zero. The index is not wrapped, and `old_dest` has no effect.
- R8: Sign mode at 8-byte size with index 7, 15 or 31 gives the standard byte, half-word and word sign extension to 64 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_sign | input | 1 | 1 = sign extend, 0 = zero extend |
| size_code | input | 2 | Operand size code |
| bit_idx | input | 6 | Extension bit index |
| src | input | 64 | Source value |
| old_dest | input | 64 | Previous destination value |
| flag_upd | input | 1 | Request flag update |
| flag_mask | input | 4 | Flag enable mask |
| old_flags | input | 4 | Previous flag bits |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Merged destination value |
| flags_out | output | 4 | Updated flag bits |

## Verification
The hardest case to reach is an index above the operand size. Here the wrapped position, the sign fill and the byte merge all act at once. The stimulus drives index 12 at byte size and index 40 at half-word size, with an `old_dest` whose bytes are all distinct, so a missing wrap or a wrong merge boundary shows up as a wrong byte. Flag cases pair a partial mask with both polarities of the sign bit, and the old flags are set to the opposite polarity. This way both the bits that must change and the bits that must stay are visible.

// File: rtl/sx_zx_unit.sv
module sx_zx_unit #(
  parameter int W  = 64,
  parameter int NF = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 op_sign,
  input  logic [1:0]           size_code,
  input  logic [$clog2(W)-1:0] bit_idx,
  input  logic [W-1:0]         src,
  input  logic [W-1:0]         old_dest,
  input  logic                 flag_upd,
  input  logic [NF-1:0]        flag_mask,
  input  logic [NF-1:0]        old_flags,
  output logic                 out_valid,
  output logic [W-1:0]         result,
  output logic [NF-1:0]        flags_out
);
  localparam int IW = $clog2(W);

  logic [IW:0]    size_bits;
  logic [IW-1:0]  pos;
  logic           sign_bit;
  logic [W-1:0]   low_mask, size_mask, sext_val, merged, zmask, zval;
  logic [NF-1:0]  sel, new_flags;

  assign size_bits = (IW+1)'(8) << size_code;
  assign pos       = bit_idx & IW'(size_bits - 1'b1);
  assign sign_bit  = src[pos];
  assign low_mask  = ~(({W{1'b1}} << pos) << 1);
  assign sext_val  = sign_bit ? (src | ~low_mask) : (src & low_mask);
  assign size_mask = ~({W{1'b1}} << size_bits);
  assign merged    = (old_dest & ~size_mask) | (sext_val & size_mask);
  assign zmask     = ~(({W{1'b1}} << bit_idx) << 1);
  assign zval      = src & zmask;
  assign sel       = (flag_upd && op_sign) ? flag_mask : '0;
  assign new_flags = (old_flags & ~sel) | (sel & {NF{sign_bit}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= op_sign ? merged : zval;
        flags_out <= new_flags;
      end
    end
  end

  assert_valid_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_merge_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sign && size_code == 2'd0) |=> result[W-1:8] == $past(old_dest[W-1:8]));
  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(flag_upd && op_sign)) |=> flags_out == $past(old_flags));
  assert_zero_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_sign) |=> ((result >> $past(bit_idx)) >> 1) == '0);
endmodule

// File: tb/sim_sx_zx_unit.sv
module sim_sx_zx_unit;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, op_sign = 1'b0, flag_upd = 1'b0;
  logic [1:0] size_code = '0;
  logic [5:0] bit_idx = '0;
  logic [63:0] src = '0, old_dest = '0;
  logic [3:0] flag_mask = '0, old_flags = '0;
  logic out_valid;
  logic [63:0] result;
  logic [3:0] flags_out;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sx_zx_unit u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sign(op_sign),
    .size_code(size_code), .bit_idx(bit_idx), .src(src), .old_dest(old_dest),
    .flag_upd(flag_upd), .flag_mask(flag_mask), .old_flags(old_flags),
    .out_valid(out_valid), .result(result), .flags_out(flags_out));

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(string req, bit sgn, int sz, int idx, logic [63:0] s, logic [63:0] od,
                     bit fu, logic [3:0] fm, logic [3:0] of);
    logic [63:0] exp;
    logic [3:0] ef;
    int nb, p;
    bit sb;
    nb = 8 * (1 << sz);
    p = idx % nb;
    sb = s[p];
    for (int i = 0; i < 64; i++) begin
      if (sgn) exp[i] = (i >= nb) ? od[i] : ((i <= p) ? s[i] : sb);
      else     exp[i] = (i <= idx) ? s[i] : 1'b0;
    end
    for (int k = 0; k < 4; k++) ef[k] = (sgn && fu && fm[k]) ? sb : of[k];
    @(negedge clk);
    in_valid = 1'b1; op_sign = sgn; size_code = 2'(sz); bit_idx = 6'(idx);
    src = s; old_dest = od; flag_upd = fu; flag_mask = fm; old_flags = of;
    @(negedge clk);
    in_valid = 1'b0;
    check64({req, " valid"}, 64'(out_valid), 64'd1);
    check64({req, " result"}, result, exp);
    check64({req, " flags"}, 64'(flags_out), 64'(ef));
  endtask

  task automatic t_reset;
    check64("R1 reset valid", 64'(out_valid), 64'd0);
    check64("R1 reset result", result, 64'd0);
    check64("R1 reset flags", 64'(flags_out), 64'd0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    check64("R1 idle valid low", 64'(out_valid), 64'd0);
  endtask

  task automatic t_standard;
    run("R8 byte neg", 1, 3, 7, 64'h1234_5678_9abc_de80, 64'hffff, 0, 4'h0, 4'h0);
    run("R8 half pos", 1, 3, 15, 64'hffff_ffff_ffff_7fff, 64'h0, 0, 4'h0, 4'h5);
    run("R8 word neg", 1, 3, 31, 64'h0000_0000_8000_0001, 64'h0, 0, 4'h0, 4'h0);
  endtask

  task automatic t_wrap_merge;
    run("R2 R4 byte wrap", 1, 0, 12, 64'h0000_0000_0000_0010, 64'h0102_0304_0506_0708, 0, 4'h0, 4'h0);
    run("R2 R3 half wrap", 1, 1, 40, 64'h0000_0000_0000_01ff, 64'h1122_3344_5566_7788, 0, 4'h0, 4'h0);
    run("R3 R4 word pos", 1, 2, 20, 64'hdead_beef_00ef_ffff, 64'hcafe_f00d_0000_0000, 0, 4'h0, 4'h0);
    run("R3 full top", 1, 3, 63, 64'h8000_0000_0000_0000, 64'h0, 0, 4'h0, 4'h0);
  endtask

  task automatic t_flags;
    run("R5 set partial", 1, 3, 7, 64'h80, 64'h0, 1, 4'b0101, 4'b0000);
    run("R5 clear partial", 1, 3, 7, 64'h7f, 64'h0, 1, 4'b1010, 4'b1111);
    run("R6 no update", 1, 3, 7, 64'h80, 64'h0, 0, 4'hf, 4'b0110);
  endtask

  task automatic t_zero;
    run("R7 zero byte", 0, 3, 7, 64'hffff_ffff_ffff_ffff, 64'h1234, 1, 4'hf, 4'b1001);
    run("R7 zero unwrapped", 0, 0, 40, 64'hffff_ffff_ffff_ffff, 64'hffff, 0, 4'h0, 4'h0);
    run("R7 zero full", 0, 3, 63, 64'h8123_4567_89ab_cdef, 64'h0, 0, 4'h0, 4'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_idle();
    t_standard();
    t_wrap_merge();
    t_flags();
    t_zero();
    t_idle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule